// File: doc/BRIEF.md
# RTC Alarm Match and Event Flags

This block sits beside a real-time-clock time keeper. It compares the running BCD seconds, minutes and hours against three programmable alarm registers. Bit 7 of each alarm register is a mask: a field whose mask is set drops out of the comparison. The comparison runs once per one-second tick. A small two-state evaluator (`EV_IDLE`, `EV_CHECK`) performs it. The move `EV_IDLE -> EV_CHECK` happens when a tick is sampled. `EV_CHECK` stays in `EV_CHECK` if another tick is present and otherwise returns to `EV_IDLE`. The comparison is made only while in `EV_CHECK`.

A flags register gathers sticky event bits:
- the alarm match,
- watchdog expiry,
- power fail,
- oscillator failure.

It also holds three control bits: calibration enable, a write-hold bit and a read-hold bit. Reading the flags register returns its contents and clears the alarm, watchdog and power-fail bits in the same cycle. The oscillator-fail bit ignores reads and reset, and only a software write can clear it.

The interrupt output normally reports any pending alarm, watchdog or power-fail event. With calibration enabled it carries a square wave instead. That wave is the 32.768 kHz reference enable divided by 64, which gives 512 Hz.

Top module: `rtc_alarm_flags`

## Requirements
- R1: After `rst_n` is released, the three alarm registers read 0x00, `rdata` is 0x00, flag bits 7, 6, 5, 3, 2, 1 and 0 are 0, and `int_o` is 0.
- R2: A tick sampled at one rising edge moves the evaluator to `EV_CHECK`. If every unmasked field matches the time inputs during that cycle, the alarm flag (bit 6) reads 1 after the next edge. Seconds and minutes compare alarm bits 6:0. Hours compare alarm bits 5:0, so hours bit 6 is ignored.
- R3: Alarm register bit 7 set to 1 removes that field from the match. With all three masks set, every tick sets the alarm flag.
- R4: Without a tick the alarm flag never sets, even when the time equals the alarm.
- R5: A `wd_expire` pulse sets flag bit 7 at the next edge.
- R6: `pf_in` high at an edge sets flag bit 5 at that edge.
- R7: A read (`rd_en`) at address 3 loads the flags as they were before the edge into `rdata`, and clears bits 7, 6 and 5 at that edge. Addresses 0, 1 and 2 are the seconds, minutes and hours alarm registers, and `rdata` is registered.
- R8: If an event that sets flag bit 7, 6 or 5 coincides with a flags read, the bit ends at 1.
- R9: Flag bit 4 is set by `osc_fail_set`. It is kept across flags reads and across `rst_n`. A write to address 3 with `wdata[4]`=0 clears it, and writing 1 does not set it.
- R10: A write to address 3 stores `wdata[2:0]` into bits 2 (calibration), 1 (write hold) and 0 (read hold). It has no effect on bits 7, 6 and 5, and bit 3 always reads 0.
- R11: With bit 2 at 0, `int_o` equals the OR of flag bits 7, 6 and 5. With bit 2 at 1, `int_o` starts at 0 and toggles on every 32nd `ref_en` pulse.
- R12: Writes to addresses 0, 1 and 2 store all 8 bits, and reads return them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sec_i | input | 7 | Current seconds, BCD |
| min_i | input | 7 | Current minutes, BCD |
| hr_i | input | 6 | Current hours, BCD |
| tick_1hz | input | 1 | One-second tick, one cycle wide |
| wd_expire | input | 1 | Watchdog expiry pulse |
| pf_in | input | 1 | Power-fail comparator output, high on low supply |
| osc_fail_set | input | 1 | Oscillator-failure detection pulse |
| ref_en | input | 1 | 32.768 kHz reference enable pulse |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| flags_o | output | 8 | Live flags register |
| int_o | output | 1 | Interrupt or calibration wave |

## Verification
The setting of an event flag and the clear-on-read of the flags register can land in the same cycle. The bench provokes this twice:
- It drives `wd_expire` in the very cycle it issues a flags read.
- It issues a flags read in the `EV_CHECK` cycle that follows a matching tick.

In both cases it judges that `rdata` shows the bit as it was before the edge while the flag stays at 1 afterwards. A following read of the flags register confirms that the bit then clears.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int ADDR_W  = 2;
    localparam int NFIELD  = 3;
    localparam int FIELD_W = 7;
    localparam int HOUR_W  = 6;

    localparam logic [ADDR_W-1:0] A_SEC = 2'd0;
    localparam logic [ADDR_W-1:0] A_MIN = 2'd1;
    localparam logic [ADDR_W-1:0] A_HR  = 2'd2;
    localparam logic [ADDR_W-1:0] A_FLG = 2'd3;

    localparam int FB_WDF = 7;
    localparam int FB_ALF = 6;
    localparam int FB_PWF = 5;
    localparam int FB_OSF = 4;
    localparam int FB_CAL = 2;

    typedef enum logic {
        EV_IDLE,
        EV_CHECK
    } ev_state_e;
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int NF   = NFIELD,
    parameter int FW   = FIELD_W,
    parameter int HR_W = HOUR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [NF*FW-1:0] cur_flat,
    input  logic [NF*8-1:0]  alm_flat,
    output logic            hit
);
    ev_state_e state, nxt;
    logic [NF-1:0] field_ok;

    for (genvar g = 0; g < NF; g++) begin : g_field
        localparam logic [FW-1:0] CMP = (g == NF-1) ? FW'((1 << HR_W) - 1) : {FW{1'b1}};
        assign field_ok[g] = alm_flat[g*8+7] |
            (((alm_flat[g*8 +: FW] ^ cur_flat[g*FW +: FW]) & CMP) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= EV_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        hit = 1'b0;
        unique case (state)
            EV_IDLE: begin
                if (tick) nxt = EV_CHECK;
            end
            EV_CHECK: begin
                hit = &field_ok;
                nxt = tick ? EV_CHECK : EV_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank
    import rtc_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alarm_hit,
    input  logic       wd_expire,
    input  logic       pf_in,
    input  logic       osc_fail_set,
    input  logic       rd_clr,
    input  logic       wr_flag,
    input  logic [7:0] wdata,
    output logic [7:0] flags
);
    logic       wdf, alf, pwf, osf;
    logic [2:0] ctrl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdf  <= 1'b0;
            alf  <= 1'b0;
            pwf  <= 1'b0;
            ctrl <= 3'b000;
        end else begin
            wdf <= wd_expire | (wdf & ~rd_clr);
            alf <= alarm_hit | (alf & ~rd_clr);
            pwf <= pf_in     | (pwf & ~rd_clr);
            if (wr_flag) ctrl <= wdata[2:0];
        end
    end

    // Battery-domain bit: untouched by the logic reset.
    always_ff @(posedge clk) begin
        if (osc_fail_set)                 osf <= 1'b1;
        else if (wr_flag && !wdata[FB_OSF]) osf <= 1'b0;
    end

    always_comb begin
        flags          = 8'h00;
        flags[FB_WDF]  = wdf;
        flags[FB_ALF]  = alf;
        flags[FB_PWF]  = pwf;
        flags[FB_OSF]  = osf;
        flags[2:0]     = ctrl;
    end
endmodule

// File: rtl/rtc_cal_wave.sv
module rtc_cal_wave #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ref_en,
    output logic wave
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            wave <= 1'b0;
        end else if (!en) begin
            cnt  <= '0;
            wave <= 1'b0;
        end else if (ref_en) begin
            if (cnt == CW'(HALF - 1)) begin
                cnt  <= '0;
                wave <= ~wave;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_alarm_flags.sv
module rtc_alarm_flags
    import rtc_alarm_pkg::*;
#(
    parameter int CAL_DIV = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        sec_i,
    input  logic [6:0]        min_i,
    input  logic [5:0]        hr_i,
    input  logic              tick_1hz,
    input  logic              wd_expire,
    input  logic              pf_in,
    input  logic              osc_fail_set,
    input  logic              ref_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [7:0]        flags_o,
    output logic              int_o
);
    logic [7:0]            alm [NFIELD];
    logic [NFIELD*8-1:0]   alm_flat;
    logic [NFIELD*FIELD_W-1:0] cur_flat;
    logic                  alarm_hit;
    logic [7:0]            flags;
    logic                  wave;
    logic [7:0]            rd_mux;
    logic                  rd_clr, wr_flag;

    assign rd_clr  = rd_en & (addr == A_FLG);
    assign wr_flag = wr_en & (addr == A_FLG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NFIELD; i++) alm[i] <= 8'h00;
        end else begin
            for (int i = 0; i < NFIELD; i++)
                if (wr_en && addr == ADDR_W'(i)) alm[i] <= wdata;
        end
    end

    for (genvar g = 0; g < NFIELD; g++) begin : g_flat
        assign alm_flat[g*8 +: 8] = alm[g];
    end
    assign cur_flat = {{(FIELD_W-HOUR_W){1'b0}}, hr_i, min_i, sec_i};

    rtc_alarm_match u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1hz),
        .cur_flat (cur_flat),
        .alm_flat (alm_flat),
        .hit      (alarm_hit)
    );

    rtc_flag_bank u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .alarm_hit    (alarm_hit),
        .wd_expire    (wd_expire),
        .pf_in        (pf_in),
        .osc_fail_set (osc_fail_set),
        .rd_clr       (rd_clr),
        .wr_flag      (wr_flag),
        .wdata        (wdata),
        .flags        (flags)
    );

    rtc_cal_wave #(.DIV(CAL_DIV)) u_cal (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (flags[FB_CAL]),
        .ref_en (ref_en),
        .wave   (wave)
    );

    always_comb begin
        unique case (addr)
            A_SEC:   rd_mux = alm[0];
            A_MIN:   rd_mux = alm[1];
            A_HR:    rd_mux = alm[2];
            default: rd_mux = flags;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= 8'h00;
        else if (rd_en) rdata <= rd_mux;
    end

    assign flags_o = flags;
    assign int_o   = flags[FB_CAL] ? wave
                   : (flags[FB_WDF] | flags[FB_ALF] | flags[FB_PWF]);
endmodule

// File: rtl/rtc_alarm_flags_chk.sv
module rtc_alarm_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1hz,
    input logic       wd_expire,
    input logic       pf_in,
    input logic [1:0] addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic [7:0] flags_o,
    input logic       alarm_hit
);
    a_r5_wdog_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> flags_o[7]);

    a_r6_pf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        pf_in |=> flags_o[5]);

    a_r8_alarm_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> flags_o[6]);

    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd3 && !wd_expire && !pf_in && !alarm_hit)
        |=> (flags_o[7:5] == 3'b000));

    a_r9_osc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[4] && !(wr_en && addr == 2'd3 && !wdata[4])) |=> flags_o[4]);

    a_r4_alarm_needs_eval: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags_o[6] && !alarm_hit) |=> !flags_o[6]);

    a_r2_hit_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> $past(tick_1hz));
endmodule

bind rtc_alarm_flags rtc_alarm_flags_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1hz  (tick_1hz),
    .wd_expire (wd_expire),
    .pf_in     (pf_in),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .flags_o   (flags_o),
    .alarm_hit (alarm_hit)
);

// File: tb/rtc_alarm_flags_tb.sv
module rtc_alarm_flags_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] sec_i = '0, min_i = '0;
    logic [5:0] hr_i = '0;
    logic       tick_1hz = 0, wd_expire = 0, pf_in = 0, osc_fail_set = 0, ref_en = 0;
    logic [1:0] addr = '0;
    logic       wr_en = 0, rd_en = 0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, flags_o;
    logic       int_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    rtc_alarm_flags u_dut (.*);

    typedef struct packed {
        logic [7:0] ts, tm, th, as, am, ah;
        logic       ex;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{8'h56, 8'h34, 8'h12, 8'h56, 8'h34, 8'h12, 1'b1},
        '{8'h56, 8'h34, 8'h12, 8'h57, 8'h34, 8'h12, 1'b0},
        '{8'h56, 8'h34, 8'h12, 8'h80, 8'h34, 8'h12, 1'b1},
        '{8'h56, 8'h34, 8'h12, 8'h56, 8'h35, 8'h12, 1'b0},
        '{8'h56, 8'h34, 8'h12, 8'h56, 8'hB5, 8'h12, 1'b1},
        '{8'h59, 8'h59, 8'h23, 8'h59, 8'h59, 8'h81, 1'b1},
        '{8'h59, 8'h59, 8'h23, 8'h59, 8'h59, 8'h22, 1'b0},
        '{8'h00, 8'h00, 8'h00, 8'h80, 8'h80, 8'h80, 1'b1},
        '{8'h56, 8'h34, 8'h12, 8'h56, 8'h34, 8'h52, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a);
        addr = a; rd_en = 1;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic tick();
        tick_1hz = 1;
        @(negedge clk);
        tick_1hz = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog timeout");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        chk("R1 flags", flags_o & 8'hEF, 8'h00);
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 int", int_o, 1'b0);
        rd(2'd2);
        chk("R1 alarm hours", rdata, 8'h00);

        // R9 oscillator-fail stickiness
        osc_fail_set = 1; cyc(1); osc_fail_set = 0;
        chk("R9 set", flags_o[4], 1'b1);
        rd(2'd3);
        chk("R9 read value", rdata, 8'h10);
        chk("R9 survives read", flags_o[4], 1'b1);
        rst_n = 0; cyc(2); rst_n = 1; cyc(1);
        chk("R9 survives reset", flags_o[4], 1'b1);
        wr(2'd3, 8'h10);
        chk("R9 write 1 keeps", flags_o[4], 1'b1);
        wr(2'd3, 8'h00);
        chk("R9 write 0 clears", flags_o[4], 1'b0);

        // R2 / R3 vector table
        foreach (VEC[i]) begin
            rd(2'd3);
            wr(2'd0, VEC[i].as);
            wr(2'd1, VEC[i].am);
            wr(2'd2, VEC[i].ah);
            sec_i = VEC[i].ts[6:0];
            min_i = VEC[i].tm[6:0];
            hr_i  = VEC[i].th[5:0];
            tick();
            chk($sformatf("R2 R3 vector %0d alarm flag", i), flags_o[6], VEC[i].ex);
            chk($sformatf("R11 vector %0d int", i), int_o, VEC[i].ex);
        end

        // R12 alarm register storage
        wr(2'd1, 8'hA5); rd(2'd1);
        chk("R12 minutes readback", rdata, 8'hA5);
        wr(2'd0, 8'h7F); rd(2'd0);
        chk("R12 seconds readback", rdata, 8'h7F);

        // R4 no tick no alarm
        wr(2'd0, 8'h10); wr(2'd1, 8'h20); wr(2'd2, 8'h08);
        sec_i = 7'h10; min_i = 7'h20; hr_i = 6'h08;
        rd(2'd3);
        cyc(6);
        chk("R4 no tick", flags_o[6], 1'b0);
        tick();
        chk("R4 tick sets", flags_o[6], 1'b1);
        rd(2'd3);
        chk("R7 alarm read value", rdata, 8'h40);
        cyc(5);
        chk("R4 no re-set without tick", flags_o[6], 1'b0);

        // R5 R6 R7
        wd_expire = 1; cyc(1); wd_expire = 0;
        chk("R5 watchdog flag", flags_o[7], 1'b1);
        pf_in = 1; cyc(1); pf_in = 0;
        chk("R6 power-fail flag", flags_o[5], 1'b1);
        rd(2'd3);
        chk("R7 read value", rdata, 8'hA0);
        chk("R7 cleared", flags_o & 8'hE0, 8'h00);

        // R8 set wins over read
        addr = 2'd3; rd_en = 1; wd_expire = 1;
        cyc(1);
        rd_en = 0; wd_expire = 0;
        chk("R8 rdata old", rdata[7], 1'b0);
        chk("R8 watchdog kept", flags_o[7], 1'b1);
        rd(2'd3);
        chk("R8 later read clears", flags_o[7], 1'b0);
        tick_1hz = 1; cyc(1); tick_1hz = 0;
        addr = 2'd3; rd_en = 1; cyc(1); rd_en = 0;
        chk("R8 alarm kept", flags_o[6], 1'b1);
        rd(2'd3);
        chk("R8 alarm clears", flags_o[6], 1'b0);

        // R10 writable bits
        wr(2'd3, 8'hEF);
        chk("R10 flags after write", flags_o, 8'h07);
        wr(2'd3, 8'h00);
        chk("R10 ctrl cleared", flags_o, 8'h00);

        // R11 calibration wave
        wd_expire = 1; cyc(1); wd_expire = 0;
        chk("R11 normal int", int_o, 1'b1);
        wr(2'd3, 8'h04);
        chk("R11 cal start low", int_o, 1'b0);
        repeat (31) begin ref_en = 1; cyc(1); end
        ref_en = 0; cyc(2);
        chk("R11 before 32nd", int_o, 1'b0);
        ref_en = 1; cyc(1); ref_en = 0;
        chk("R11 after 32nd", int_o, 1'b1);
        repeat (32) begin ref_en = 1; cyc(1); end
        ref_en = 0;
        chk("R11 after 64th", int_o, 1'b0);
        wr(2'd3, 8'h00);
        chk("R11 back to normal", int_o, 1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule